// File: doc/BRIEF.md
# Multi-CPU Interrupt Routing Controller

This block routes a set of level-sensitive interrupt sources to up to four CPUs. A shared register bank holds one global enable per source and a per-source target word that says which CPUs may receive it. A per-CPU register bank holds that CPU's mask bits and an acknowledge register. Enables and masks are not written as bitmaps. Software writes a source index to a dedicated set register or a dedicated clear register, so no read-modify-write is needed.

Each CPU has one interrupt line. The line is high while at least one source qualifies for that CPU. Reading the acknowledge register returns the lowest-numbered qualifying source, or 1023 when nothing qualifies. Three source numbers are special. Sources 0 and 1 carry each CPU's doorbell summaries (inter-processor and message-signalled). Source 5 carries each CPU's private timer. All three ignore the global enable and the target word, and the CPU's own mask alone gates them.

A register access carries a bank select (0 = shared, 1 = per-CPU) and, for the per-CPU bank, the number of the CPU making the access. Read data is returned one cycle after the read strobe.

Top module: `irq_router`

## Requirements
- R1: A read of shared offset 0x000 returns the number of implemented sources (32) in bits [11:2], with every other bit zero.
- R2: After reset, all global enables are clear, all per-CPU masks are set and all target words are zero. Every interrupt line is low and every acknowledge read returns 1023.
- R3: A write of index i to shared offset 0x030 sets the global enable of source i, and a write to 0x034 clears it. An index of 32 or more changes nothing; in particular it does not alias to a lower source.
- R4: A write of index i to per-CPU offset 0x048 masks source i for the accessing CPU only, and a write to 0x04C unmasks it. An index of 32 or more changes nothing.
- R5: The target word of source i sits at shared offset 0x100 + 4*i. Its low 4 bits (bit c = CPU c) are writable and read back unchanged, and the upper bits read as zero.
- R6: An ordinary source (any number other than 0, 1 and 5) reaches CPU c only when its input line is high, its global enable is set, its target bit c is set and CPU c has it unmasked.
- R7: Source 0 for CPU c follows that CPU's inter-processor doorbell input, and source 1 follows its message doorbell input. Each is gated only by CPU c's mask. The shared input lines 0 and 1 have no effect.
- R8: Source 5 for CPU c follows CPU c's private timer input and is gated only by CPU c's mask. Shared input line 5, the global enable of source 5 and its target word have no effect.
- R9: A read of per-CPU offset 0x044 returns, in bits [9:0], the lowest-numbered source that qualifies for the accessing CPU, or 1023 if none does. The read has no side effect.
- R10: The interrupt line of CPU c is high exactly while some source qualifies for it. It follows the level inputs in the same cycle, with no latching.
- R11: `rd_valid` is high for exactly the one cycle after each `rd_en` cycle, and `rd_data` holds the read result during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| bank_sel | input | 1 | 0 selects the shared bank, 1 selects the per-CPU bank |
| cpu_id | input | 2 | CPU making the per-CPU access |
| addr | input | 12 | Byte offset within the selected bank |
| wdata | input | 10 | Write data: a source index, or a target field in bits [3:0] |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data |
| shared_irq | input | 32 | Level inputs of the ordinary sources |
| ipi_pend | input | 4 | Per-CPU inter-processor doorbell summary (source 0) |
| msi_pend | input | 4 | Per-CPU message doorbell summary (source 1) |
| tmr_pend | input | 4 | Per-CPU private timer request (source 5) |
| irq_o | output | 4 | Interrupt line of each CPU |

## Verification
A corrupted enable, mask or target bit shows up at the interrupt lines in the cycle after the write that caused it, because the lines are combinational from stored state. It also shows up in the acknowledge value read one cycle later. A mis-decoded index shows as a neighbouring source appearing or disappearing: an out-of-range index that aliases, for example, enables a low source that should stay silent. A priority fault shows only when two sources qualify at once. The stimulus therefore stacks two sources on one CPU, drops the lower one, and checks that the acknowledge value moves to the higher one.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int IDX_W  = 10;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [IDX_W-1:0] ACK_NONE = 10'd1023;

    // shared bank
    localparam logic [ADDR_W-1:0] A_CTRL     = 12'h000;
    localparam logic [ADDR_W-1:0] A_EN_SET   = 12'h030;
    localparam logic [ADDR_W-1:0] A_EN_CLR   = 12'h034;
    localparam logic [ADDR_W-1:0] A_TGT_BASE = 12'h100;
    // per-CPU bank
    localparam logic [ADDR_W-1:0] A_ACK      = 12'h044;
    localparam logic [ADDR_W-1:0] A_MSK_SET  = 12'h048;
    localparam logic [ADDR_W-1:0] A_MSK_CLR  = 12'h04C;

    localparam int SRC_IPI = 0;
    localparam int SRC_MSI = 1;
    localparam int SRC_TMR = 5;

    // true when addr falls on a target word of an implemented source
    function automatic logic tgt_hit(input logic [ADDR_W-1:0] a,
                                     input logic [IDX_W-1:0] nsrc);
        logic [ADDR_W-1:0] off;
        off = a - A_TGT_BASE;
        return (a >= A_TGT_BASE) && (off[ADDR_W-1:2] < nsrc) && (off[1:0] == 2'b00);
    endfunction
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
    import irq_router_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int NCPU = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            bank_sel,
    input  logic [$clog2(NCPU)-1:0]         cpu_id,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [IDX_W-1:0]                wdata,
    output logic [NSRC-1:0]                 en_o,
    output logic [NCPU-1:0][NSRC-1:0]       msk_o,
    output logic [NSRC-1:0][NCPU-1:0]       tgt_o
);
    localparam int SRC_W = $clog2(NSRC);
    localparam logic [IDX_W-1:0] NSRC_L = IDX_W'(NSRC);

    typedef struct packed {
        logic [NSRC-1:0]           en;
        logic [NCPU-1:0][NSRC-1:0] msk;
        logic [NSRC-1:0][NCPU-1:0] tgt;
    } state_t;

    state_t s_d, s_q;

    logic              idx_ok;
    logic [SRC_W-1:0]  sidx;
    logic [ADDR_W-1:0] toff;
    logic [SRC_W-1:0]  tslot;

    always_comb begin
        idx_ok = (wdata < NSRC_L);
        sidx   = wdata[SRC_W-1:0];
        toff   = addr - A_TGT_BASE;
        tslot  = toff[SRC_W+1:2];
        s_d    = s_q;
        if (wr_en) begin
            if (!bank_sel) begin
                if (addr == A_EN_SET && idx_ok) begin
                    s_d.en[sidx] = 1'b1;
                end else if (addr == A_EN_CLR && idx_ok) begin
                    s_d.en[sidx] = 1'b0;
                end else if (tgt_hit(addr, NSRC_L)) begin
                    s_d.tgt[tslot] = wdata[NCPU-1:0];
                end
            end else begin
                if (addr == A_MSK_SET && idx_ok) begin
                    s_d.msk[cpu_id][sidx] = 1'b1;
                end else if (addr == A_MSK_CLR && idx_ok) begin
                    s_d.msk[cpu_id][sidx] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.en  <= '0;
            s_q.msk <= '1;
            s_q.tgt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign en_o  = s_q.en;
    assign msk_o = s_q.msk;
    assign tgt_o = s_q.tgt;
endmodule

// File: rtl/irq_router_pick.sv
module irq_router_pick
    import irq_router_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic [NSRC-1:0]  shared_irq,
    input  logic [NSRC-1:0]  en,
    input  logic [NSRC-1:0]  msk_row,
    input  logic [NSRC-1:0]  tgt_col,
    input  logic             ipi,
    input  logic             msi,
    input  logic             tmr,
    output logic [IDX_W-1:0] ack,
    output logic             any
);
    logic [NSRC-1:0] qual;

    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            if (s == SRC_IPI) begin
                qual[s] = ipi & ~msk_row[s];
            end else if (s == SRC_MSI) begin
                qual[s] = msi & ~msk_row[s];
            end else if (s == SRC_TMR) begin
                qual[s] = tmr & ~msk_row[s];
            end else begin
                qual[s] = shared_irq[s] & en[s] & tgt_col[s] & ~msk_row[s];
            end
        end
    end

    // lowest index wins: scan from the top so the last hit is the smallest
    always_comb begin
        ack = ACK_NONE;
        for (int s = NSRC - 1; s >= 0; s--) begin
            if (qual[s]) ack = IDX_W'(s);
        end
    end

    assign any = |qual;
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int NCPU = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic                    bank_sel,
    input  logic [$clog2(NCPU)-1:0] cpu_id,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [IDX_W-1:0]        wdata,
    output logic                    rd_valid,
    output logic [DATA_W-1:0]       rd_data,
    input  logic [NSRC-1:0]         shared_irq,
    input  logic [NCPU-1:0]         ipi_pend,
    input  logic [NCPU-1:0]         msi_pend,
    input  logic [NCPU-1:0]         tmr_pend,
    output logic [NCPU-1:0]         irq_o
);
    localparam int SRC_W = $clog2(NSRC);
    localparam logic [IDX_W-1:0] NSRC_L = IDX_W'(NSRC);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_t;

    logic [NSRC-1:0]             en_w;
    logic [NCPU-1:0][NSRC-1:0]   mask_w;
    logic [NSRC-1:0][NCPU-1:0]   tgt_w;
    logic [NCPU-1:0][NSRC-1:0]   tcol_w;
    logic [NCPU-1:0][IDX_W-1:0]  ack_w;
    rd_t                         rd_d, rd_q;

    irq_router_regs #(.NSRC(NSRC), .NCPU(NCPU)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .bank_sel (bank_sel),
        .cpu_id   (cpu_id),
        .addr     (addr),
        .wdata    (wdata),
        .en_o     (en_w),
        .msk_o    (mask_w),
        .tgt_o    (tgt_w)
    );

    // transpose target words into one column per CPU
    always_comb begin
        for (int c = 0; c < NCPU; c++) begin
            for (int s = 0; s < NSRC; s++) begin
                tcol_w[c][s] = tgt_w[s][c];
            end
        end
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        irq_router_pick #(.NSRC(NSRC)) pick_i (
            .shared_irq (shared_irq),
            .en         (en_w),
            .msk_row    (mask_w[c]),
            .tgt_col    (tcol_w[c]),
            .ipi        (ipi_pend[c]),
            .msi        (msi_pend[c]),
            .tmr        (tmr_pend[c]),
            .ack        (ack_w[c]),
            .any        (irq_o[c])
        );
    end

    logic [ADDR_W-1:0] toff;
    logic [SRC_W-1:0]  tslot;

    always_comb begin
        toff       = addr - A_TGT_BASE;
        tslot      = toff[SRC_W+1:2];
        rd_d.valid = rd_en;
        rd_d.data  = '0;
        if (rd_en) begin
            if (!bank_sel) begin
                if (addr == A_CTRL) begin
                    rd_d.data = {{(DATA_W-IDX_W-2){1'b0}}, NSRC_L, 2'b00};
                end else if (tgt_hit(addr, NSRC_L)) begin
                    rd_d.data = DATA_W'(tgt_w[tslot]);
                end
            end else if (addr == A_ACK) begin
                rd_d.data = DATA_W'(ack_w[cpu_id]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid = rd_q.valid;
    assign rd_data  = rd_q.data;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int NCPU = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic                       rd_en,
    input logic                       bank_sel,
    input logic [$clog2(NCPU)-1:0]    cpu_id,
    input logic [ADDR_W-1:0]          addr,
    input logic [IDX_W-1:0]           wdata,
    input logic                       rd_valid,
    input logic [DATA_W-1:0]          rd_data,
    input logic [NCPU-1:0]            irq_o,
    input logic [NSRC-1:0]            en_w,
    input logic [NCPU-1:0][NSRC-1:0]  mask_w,
    input logic [NCPU-1:0][IDX_W-1:0] ack_w
);
    localparam int SRC_W = $clog2(NSRC);
    localparam logic [IDX_W-1:0] NSRC_L = IDX_W'(NSRC);

    logic [SRC_W-1:0]        last_idx_q;
    logic [$clog2(NCPU)-1:0] last_cpu_q;
    logic [IDX_W-1:0]        last_ack_q;

    always_ff @(posedge clk) begin
        last_idx_q <= wdata[SRC_W-1:0];
        last_cpu_q <= cpu_id;
        last_ack_q <= ack_w[cpu_id];
    end

    logic in_rng;
    assign in_rng = wdata < NSRC_L;

    // R2: reset leaves every mask set and every enable clear
    assert_reset_state_R2: assert property (@(posedge clk)
        !rst_n |=> ((&mask_w) && (en_w == '0)));

    // R3: index writes to the enable set / clear offsets
    assert_en_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bank_sel && addr == A_EN_SET && in_rng) |=> en_w[last_idx_q]);
    assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bank_sel && addr == A_EN_CLR && in_rng) |=> !en_w[last_idx_q]);

    // R4: index writes to the mask set / clear offsets of the accessing CPU
    assert_msk_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bank_sel && addr == A_MSK_SET && in_rng) |=> mask_w[last_cpu_q][last_idx_q]);
    assert_msk_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bank_sel && addr == A_MSK_CLR && in_rng) |=> !mask_w[last_cpu_q][last_idx_q]);

    // R9: acknowledge read returns the selector result of the accessing CPU
    assert_ack_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bank_sel && addr == A_ACK) |=> (rd_data == DATA_W'(last_ack_q)));

    // R11: read data valid exactly one cycle after the strobe
    assert_rd_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    assert_rd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R10: line high exactly when the selector finds a source
    for (genvar c = 0; c < NCPU; c++) begin : g_line
        assert_line_vs_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[c] == (ack_w[c] != ACK_NONE));
    end
endmodule

bind irq_router irq_router_chk #(.NSRC(NSRC), .NCPU(NCPU)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .bank_sel (bank_sel),
    .cpu_id   (cpu_id),
    .addr     (addr),
    .wdata    (wdata),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .irq_o    (irq_o),
    .en_w     (en_w),
    .mask_w   (mask_w),
    .ack_w    (ack_w)
);

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;
    localparam logic [11:0] O_CTRL   = 12'h000;
    localparam logic [11:0] O_EN_SET = 12'h030;
    localparam logic [11:0] O_EN_CLR = 12'h034;
    localparam logic [11:0] O_ACK    = 12'h044;
    localparam logic [11:0] O_MSET   = 12'h048;
    localparam logic [11:0] O_MCLR   = 12'h04C;
    localparam int          NONE     = 1023;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        bank_sel = 1'b0;
    logic [1:0]  cpu_id = '0;
    logic [11:0] addr = '0;
    logic [9:0]  wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [31:0] shared_irq = '0;
    logic [3:0]  ipi_pend = '0;
    logic [3:0]  msi_pend = '0;
    logic [3:0]  tmr_pend = '0;
    logic [3:0]  irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    irq_router dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .bank_sel(bank_sel), .cpu_id(cpu_id), .addr(addr), .wdata(wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .shared_irq(shared_irq),
        .ipi_pend(ipi_pend), .msi_pend(msi_pend), .tmr_pend(tmr_pend),
        .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_irq(input string tag, input logic [3:0] exp);
        #1;
        check(tag, 32'(irq_o), 32'(exp));
    endtask

    task automatic bus_wr(input logic bank, input int cpu, input logic [11:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; bank_sel = bank; cpu_id = 2'(cpu); addr = a; wdata = 10'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: pushes the expected word; the monitor compares it
    task automatic bus_rd(input logic bank, input int cpu, input logic [11:0] a,
                          input int exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; bank_sel = bank; cpu_id = 2'(cpu); addr = a;
        exp_q.push_back(32'(exp));
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected rd_valid", 32'(rd_valid), 32'd0);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        shared_irq = '1; ipi_pend = '1; msi_pend = '1; tmr_pend = '1;
        check_irq("R2 all masked after reset", 4'b0000);
        for (int c = 0; c < 4; c++) bus_rd(1'b1, c, O_ACK, NONE, "R2 ack after reset");
        bus_rd(1'b0, 0, O_CTRL, 32 << 2, "R1 source count");
        bus_rd(1'b0, 0, 12'h11C, 0, "R2 target word reset");
        @(negedge clk);
        shared_irq = '0; ipi_pend = '0; msi_pend = '0; tmr_pend = '0;
        check("R11 idle rd_valid low", 32'(rd_valid), 32'd0);

        // ordinary source 7 to CPU1
        bus_wr(1'b0, 0, 12'h11C, 2);
        bus_rd(1'b0, 0, 12'h11C, 2, "R5 target readback");
        bus_wr(1'b0, 0, O_EN_SET, 7);
        bus_wr(1'b1, 1, O_MCLR, 7);
        bus_wr(1'b1, 0, O_MCLR, 7);
        shared_irq[7] = 1'b1;
        check_irq("R6 src7 only to targeted CPU1", 4'b0010);
        bus_rd(1'b1, 1, O_ACK, 7, "R6 ack cpu1 src7");
        bus_rd(1'b1, 0, O_ACK, NONE, "R6 cpu0 not targeted");

        // two sources: lowest wins, level drop
        bus_wr(1'b0, 0, 12'h10C, 2);
        bus_wr(1'b0, 0, O_EN_SET, 3);
        bus_wr(1'b1, 1, O_MCLR, 3);
        shared_irq[3] = 1'b1;
        bus_rd(1'b1, 1, O_ACK, 3, "R9 lowest index wins");
        bus_rd(1'b1, 1, O_ACK, 3, "R9 ack read has no side effect");
        shared_irq[3] = 1'b0;
        bus_rd(1'b1, 1, O_ACK, 7, "R10 level drop falls back to src7");

        // per-CPU mask isolation
        bus_wr(1'b1, 0, O_MSET, 7);
        bus_rd(1'b1, 1, O_ACK, 7, "R4 cpu0 mask leaves cpu1");
        bus_wr(1'b1, 1, O_MSET, 7);
        bus_rd(1'b1, 1, O_ACK, NONE, "R4 cpu1 masked");
        check_irq("R10 line low when masked", 4'b0000);
        bus_wr(1'b1, 1, O_MCLR, 7);
        check_irq("R4 unmask restores line", 4'b0010);

        // global enable clear
        bus_wr(1'b0, 0, O_EN_CLR, 7);
        bus_rd(1'b1, 1, O_ACK, NONE, "R3 enable cleared");
        check_irq("R3 line low after clear", 4'b0000);

        // out-of-range index must not alias to source 8
        bus_wr(1'b0, 0, 12'h120, 1);
        bus_wr(1'b1, 0, O_MCLR, 8);
        shared_irq[8] = 1'b1;
        bus_wr(1'b0, 0, O_EN_SET, 40);
        bus_rd(1'b1, 0, O_ACK, NONE, "R3 index 40 ignored");
        bus_wr(1'b0, 0, O_EN_SET, 8);
        bus_rd(1'b1, 0, O_ACK, 8, "R3 src8 enabled");
        bus_wr(1'b1, 0, O_MSET, 40);
        bus_rd(1'b1, 0, O_ACK, 8, "R4 mask index 40 ignored");
        check_irq("R6 src8 on cpu0", 4'b0001);
        shared_irq[8] = 1'b0;
        check_irq("R10 level follows input", 4'b0000);

        // doorbell sources 0 and 1
        shared_irq[0] = 1'b1; shared_irq[1] = 1'b1;
        bus_wr(1'b1, 2, O_MCLR, 0);
        bus_wr(1'b1, 2, O_MCLR, 1);
        bus_rd(1'b1, 2, O_ACK, NONE, "R7 shared lines 0/1 ignored");
        ipi_pend[3] = 1'b1;
        check_irq("R7 cpu3 doorbell masked", 4'b0000);
        ipi_pend[2] = 1'b1;
        check_irq("R7 cpu2 ipi doorbell", 4'b0100);
        bus_rd(1'b1, 2, O_ACK, 0, "R7 ack src0 without enable");
        msi_pend[2] = 1'b1;
        bus_wr(1'b1, 2, O_MSET, 0);
        bus_rd(1'b1, 2, O_ACK, 1, "R7 ack src1 msi doorbell");
        msi_pend[2] = 1'b0;
        bus_rd(1'b1, 2, O_ACK, NONE, "R7 msi drop");

        // private timer source 5
        shared_irq[5] = 1'b1;
        tmr_pend = 4'b1000;
        bus_wr(1'b0, 0, O_EN_SET, 5);
        bus_wr(1'b0, 0, 12'h114, 1);
        bus_wr(1'b1, 0, O_MCLR, 5);
        bus_rd(1'b1, 0, O_ACK, NONE, "R8 shared line 5 ignored");
        bus_wr(1'b1, 3, O_MCLR, 5);
        bus_rd(1'b1, 3, O_ACK, 5, "R8 cpu3 timer");
        bus_wr(1'b0, 0, O_EN_CLR, 5);
        bus_rd(1'b1, 3, O_ACK, 5, "R8 global enable no effect");
        check_irq("R8 timer line cpu3 only", 4'b1000);

        repeat (3) @(negedge clk);
        check("R11 all reads returned", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule